// File: doc/BRIEF.md
# Receive Sampling Tap Sweep Tuner

This block searches for a good receive sampling tap on a high-speed eMMC link. After a start request it walks the candidate taps in rising order. For each tap it presents the value together with an update flag, then waits until the flag has been cleared by the delay line, which marks the tap as applied. It then asks an external tester for one tuning test and takes its pass or fail answer. If the flag is not cleared within a bounded number of cycles, that tap counts as failing and is not tested.

While it sweeps, the engine keeps the length of the current run of passing taps. It also keeps the best run seen so far and the tap where that best run ended. When the sweep is over, it moves back from the end of the best run by half the run length. It applies that tap with the same update handshake and reports it as the final tap. If no tap passed, it raises an error and applies nothing. A one-cycle done pulse closes every search.

Top module: `tap_sweep_tuner`

## Requirements
- R1: After reset, done_o, err_o, tap_upd_o and test_req_o are 0, and tap_o and final_tap_o are 0.
- R2: After start_i, the taps 0 to NUM_TAPS-1 are applied in rising order. Each one appears on tap_o with tap_upd_o raised. tap_upd_o stays high, with tap_o steady, until tap_upd_clr_i is seen high.
- R3: If tap_upd_clr_i is not seen within UPD_TIMEOUT cycles of tap_upd_o rising, tap_upd_o falls after exactly UPD_TIMEOUT cycles. That tap then counts as failing, and no test is requested for it.
- R4: After a tap is applied, test_req_o rises and stays high until test_vld_i is seen. The pass bit is test_pass_i, taken in the same cycle as test_vld_i. test_req_o and tap_upd_o are never high together, so at most one test is outstanding.
- R5: A passing tap extends the current run of passing taps, and a failing tap sets it back to zero. The best run is replaced only when the current run is strictly longer, so between runs of equal length the earliest one wins.
- R6: The final tap equals the last tap of the best run minus floor(best length / 2). It is applied through the R2 handshake and is held on final_tap_o.
- R7: If no tap passed, err_o is raised, done_o pulses, and no final update is made.
- R8: If the final update is not cleared within UPD_TIMEOUT cycles, err_o is raised with the done pulse.
- R9: done_o is high for exactly one cycle at the end of each search. err_o holds its value until the next accepted start.
- R10: A start_i pulse while a search is running is ignored and does not change the search result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a search (accepted only when idle) |
| tap_o | output | TAP_W | Tap value being applied |
| tap_upd_o | output | 1 | Update flag, held until cleared or timed out |
| tap_upd_clr_i | input | 1 | The update flag has self-cleared (tap applied) |
| test_req_o | output | 1 | Tuning test request |
| test_vld_i | input | 1 | Test result valid |
| test_pass_i | input | 1 | Test result: 1 = pass |
| done_o | output | 1 | One-cycle pulse at the end of a search |
| err_o | output | 1 | Search failed (no passing tap or final update timeout) |
| final_tap_o | output | TAP_W | Chosen tap |

## Verification
The bench builds the tuner with NUM_TAPS=8, TAP_W=4 and UPD_TIMEOUT=4. Eight taps are few enough that all 256 pass/fail patterns can be swept. That sweep covers ties, runs that touch either end of the range, the all-fail case and every window length. The short timeout lets the bench make updates time out on chosen taps and on the final tap, and measure how long the flag stays high. A start pulse during a busy search is also injected.

// File: rtl/tap_tune_pkg.sv
package tap_tune_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LAUNCH,
    ST_UPD,
    ST_TEST,
    ST_STEP,
    ST_FLAUNCH,
    ST_FUPD
  } tune_st_e;

  // centre of a window given its last tap and its length
  function automatic int unsigned win_centre(input int unsigned last_tap,
                                             input int unsigned len);
    return last_tap - (len / 2);
  endfunction

endpackage

// File: rtl/tap_apply.sv
module tap_apply #(
  parameter int TAP_W       = 6,
  parameter int UPD_TIMEOUT = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic [TAP_W-1:0] val_i,
  input  logic             clr_i,
  output logic [TAP_W-1:0] tap_o,
  output logic             upd_o,
  output logic             ok_o,
  output logic             tmo_o
);
  localparam int CW = $clog2(UPD_TIMEOUT + 1);

  logic [TAP_W-1:0] tap_q;
  logic             upd_q;
  logic [CW-1:0]    cnt_q;
  logic             wait_last;

  assign wait_last = (cnt_q == CW'(UPD_TIMEOUT - 1));
  assign ok_o      = upd_q & clr_i;
  assign tmo_o     = upd_q & ~clr_i & wait_last;
  assign tap_o     = tap_q;
  assign upd_o     = upd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap_q <= '0;
      upd_q <= 1'b0;
      cnt_q <= '0;
    end else if (go_i) begin
      tap_q <= val_i;
      upd_q <= 1'b1;
      cnt_q <= '0;
    end else if (upd_q) begin
      if (ok_o || tmo_o) upd_q <= 1'b0;
      else               cnt_q <= cnt_q + CW'(1);
    end
  end

  // R2: the tap value may not move while its update is pending
  a_r2_tap_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_q && $past(upd_q)) |-> $stable(tap_q));

  // R3: the wait counter stays inside the timeout window
  a_r3_wait_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |-> (int'(cnt_q) < UPD_TIMEOUT));

  // R4: a new update is never launched over a pending one
  a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |-> !upd_q);

endmodule

// File: rtl/streak_track.sv
module streak_track #(
  parameter int TAP_W = 6,
  parameter int CW    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             hit_i,
  input  logic             pass_i,
  input  logic [TAP_W-1:0] idx_i,
  output logic [CW-1:0]    best_len_o,
  output logic [TAP_W-1:0] best_end_o
);
  logic [CW-1:0]    cur_q;
  logic [CW-1:0]    best_q;
  logic [TAP_W-1:0] end_q;
  logic [CW-1:0]    cur_next;
  logic             beats_best;

  assign cur_next   = cur_q + CW'(1);
  assign beats_best = (cur_next > best_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      best_q <= '0;
      end_q  <= '0;
    end else if (clear_i) begin
      cur_q  <= '0;
      best_q <= '0;
      end_q  <= '0;
    end else if (hit_i) begin
      if (pass_i) begin
        cur_q <= cur_next;
        if (beats_best) begin
          best_q <= cur_next;
          end_q  <= idx_i;
        end
      end else begin
        cur_q <= '0;
      end
    end
  end

  assign best_len_o = best_q;
  assign best_end_o = end_q;

  // R5: the running streak never exceeds the recorded best
  a_r5_cur_within_best: assert property (@(posedge clk) disable iff (!rst_n)
    cur_q <= best_q);

  // R5: without a clear the best length never shrinks
  a_r5_best_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_i |=> best_q >= $past(best_q));

endmodule

// File: rtl/tap_sweep_tuner.sv
module tap_sweep_tuner
  import tap_tune_pkg::*;
#(
  parameter int TAP_W       = 6,
  parameter int NUM_TAPS    = 40,
  parameter int UPD_TIMEOUT = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic [TAP_W-1:0] tap_o,
  output logic             tap_upd_o,
  input  logic             tap_upd_clr_i,
  output logic             test_req_o,
  input  logic             test_vld_i,
  input  logic             test_pass_i,
  output logic             done_o,
  output logic             err_o,
  output logic [TAP_W-1:0] final_tap_o
);
  localparam int               CW       = $clog2(NUM_TAPS + 1);
  localparam logic [TAP_W-1:0] LAST_TAP = TAP_W'(NUM_TAPS - 1);

  tune_st_e         state_q;
  logic [TAP_W-1:0] idx_q;
  logic [TAP_W-1:0] final_q;
  logic             done_q;
  logic             err_q;

  // named internal events
  logic             apl_go;
  logic [TAP_W-1:0] apl_val;
  logic             apl_ok;
  logic             apl_tmo;
  logic             rec_hit;
  logic             rec_pass;
  logic             trk_clear;
  logic             sweep_last;
  logic [CW-1:0]    best_len;
  logic [TAP_W-1:0] best_end;

  assign apl_go     = (state_q == ST_LAUNCH) || (state_q == ST_FLAUNCH);
  assign apl_val    = (state_q == ST_FLAUNCH) ? final_q : idx_q;
  assign rec_hit    = ((state_q == ST_UPD) && apl_tmo) ||
                      ((state_q == ST_TEST) && test_vld_i);
  assign rec_pass   = (state_q == ST_TEST) && test_pass_i;
  assign trk_clear  = (state_q == ST_IDLE) && start_i;
  assign sweep_last = (idx_q == LAST_TAP);

  tap_apply #(.TAP_W(TAP_W), .UPD_TIMEOUT(UPD_TIMEOUT)) u_apply (
    .clk   (clk),
    .rst_n (rst_n),
    .go_i  (apl_go),
    .val_i (apl_val),
    .clr_i (tap_upd_clr_i),
    .tap_o (tap_o),
    .upd_o (tap_upd_o),
    .ok_o  (apl_ok),
    .tmo_o (apl_tmo)
  );

  streak_track #(.TAP_W(TAP_W), .CW(CW)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (trk_clear),
    .hit_i      (rec_hit),
    .pass_i     (rec_pass),
    .idx_i      (idx_q),
    .best_len_o (best_len),
    .best_end_o (best_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      final_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          idx_q   <= '0;
          final_q <= '0;
          err_q   <= 1'b0;
          state_q <= ST_LAUNCH;
        end
        ST_LAUNCH: state_q <= ST_UPD;
        ST_UPD: begin
          if (apl_ok)       state_q <= ST_TEST;
          else if (apl_tmo) state_q <= ST_STEP;
        end
        ST_TEST: if (test_vld_i) state_q <= ST_STEP;
        ST_STEP: begin
          if (!sweep_last) begin
            idx_q   <= idx_q + TAP_W'(1);
            state_q <= ST_LAUNCH;
          end else if (best_len == '0) begin
            err_q   <= 1'b1;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            final_q <= TAP_W'(win_centre(32'(best_end), 32'(best_len)));
            state_q <= ST_FLAUNCH;
          end
        end
        ST_FLAUNCH: state_q <= ST_FUPD;
        ST_FUPD: begin
          if (apl_ok) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (apl_tmo) begin
            err_q   <= 1'b1;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign test_req_o  = (state_q == ST_TEST);
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign final_tap_o = final_q;

  // R4: one outstanding operation at a time
  a_r4_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    test_req_o |-> !tap_upd_o);

  // R9: done is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7: an error appears together with the done pulse
  a_r7_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> done_o);

  // R2: every applied tap lies inside the swept range
  a_r2_tap_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    tap_upd_o |-> (int'(tap_o) < NUM_TAPS));

endmodule

// File: tb/tap_sweep_tuner_bench.sv
module tap_sweep_tuner_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TW  = 4;
  localparam int N   = 8;
  localparam int TMO = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [TW-1:0] tap_o;
  logic          tap_upd_o;
  logic          tap_upd_clr_i = 1'b0;
  logic          test_req_o;
  logic          test_vld_i = 1'b0;
  logic          test_pass_i = 1'b0;
  logic          done_o;
  logic          err_o;
  logic [TW-1:0] final_tap_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tap_sweep_tuner #(.TAP_W(TW), .NUM_TAPS(N), .UPD_TIMEOUT(TMO)) u_tap_sweep_tuner (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .tap_o         (tap_o),
    .tap_upd_o     (tap_upd_o),
    .tap_upd_clr_i (tap_upd_clr_i),
    .test_req_o    (test_req_o),
    .test_vld_i    (test_vld_i),
    .test_pass_i   (test_pass_i),
    .done_o        (done_o),
    .err_o         (err_o),
    .final_tap_o   (final_tap_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // longest run scanned from its start; earliest wins on a tie
  task automatic best_window(input logic [N-1:0] e, output int len, output int ctr);
    int run = 0;
    int bst = 0;
    len = 0;
    for (int i = 0; i < N; i++) begin
      if (e[i]) begin
        run++;
        if (run > len) begin
          len = run;
          bst = i - run + 1;
        end
      end else begin
        run = 0;
      end
    end
    ctr = bst + (len - 1) - (len / 2);
  endtask

  task automatic run_case(input logic [N-1:0] pm, input logic [N-1:0] fm,
                          input bit fin_fail, input bit poke);
    int  exp_len, exp_ctr;
    int  nupd = 0;
    int  age = 0;
    int  cyc = 0;
    int  fin_tap = -1;
    bit  prev_upd = 0;
    bit  refusing = 0;
    bit  order_ok = 1;
    bit  req_bad = 0;
    bit  len_bad = 0;
    bit  got_done = 0;
    bit  exp_err;
    best_window(pm & ~fm, exp_len, exp_ctr);
    exp_err = (exp_len == 0) || fin_fail;

    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    while (!got_done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      tap_upd_clr_i = 1'b0;
      test_vld_i    = 1'b0;
      test_pass_i   = 1'b0;
      start_i       = (poke && cyc == 6);
      if (done_o) begin
        got_done = 1;
      end else begin
        if (tap_upd_o) begin
          if (!prev_upd) begin
            age = 0;
            if (nupd < N) begin
              if (int'(tap_o) != nupd) order_ok = 0;
              refusing = fm[tap_o[2:0]];
            end else begin
              fin_tap  = int'(tap_o);
              refusing = fin_fail;
            end
            nupd++;
          end
          age++;
          if (age >= 2 && !refusing) tap_upd_clr_i = 1'b1;
        end else if (prev_upd && refusing && age != TMO) begin
          len_bad = 1;
        end
        if (test_req_o) begin
          if (refusing || tap_upd_o) req_bad = 1;
          test_vld_i  = 1'b1;
          test_pass_i = pm[tap_o[2:0]];
        end
      end
      prev_upd = tap_upd_o;
    end
    chk(got_done, "R9 done seen", int'(got_done), 1);
    @(negedge clk);
    chk(!done_o, "R9 done one cycle", int'(done_o), 0);
    chk(err_o == exp_err, (fin_fail ? "R8 err" : "R7 err"), int'(err_o), int'(exp_err));
    chk(order_ok && nupd == N + ((exp_len > 0) ? 1 : 0), "R2 tap order/count",
        nupd, N + ((exp_len > 0) ? 1 : 0));
    chk(!len_bad, "R3 timeout length", int'(len_bad), 0);
    chk(!req_bad, "R4 request gating", int'(req_bad), 0);
    if (exp_len > 0) begin
      chk(fin_tap == exp_ctr, "R5 R6 applied centre tap", fin_tap, exp_ctr);
      if (!fin_fail)
        chk(int'(final_tap_o) == exp_ctr, "R6 final_tap_o", int'(final_tap_o), exp_ctr);
    end else begin
      chk(fin_tap == -1, "R7 no final update", fin_tap, -1);
    end
    if (poke) chk(err_o == exp_err, "R10 busy start ignored", int'(err_o), int'(exp_err));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!done_o && !err_o && !tap_upd_o && !test_req_o, "R1 reset flags",
        {done_o, err_o, tap_upd_o, test_req_o}, 0);
    chk(tap_o == '0 && final_tap_o == '0, "R1 reset taps", int'(tap_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done_o && !err_o && !tap_upd_o && !test_req_o, "R1 idle after reset",
        {done_o, err_o, tap_upd_o, test_req_o}, 0);

    // every pass pattern over eight taps (R5 ties, edges, all-fail R7)
    for (int p = 0; p < (1 << N); p++) run_case(N'(p), '0, 1'b0, 1'b0);
    // update timeouts on chosen taps (R3)
    for (int f = 1; f < (1 << N); f += 37) run_case('1, N'(f), 1'b0, 1'b0);
    run_case(8'b1111_1111, 8'b0001_0000, 1'b0, 1'b0);
    run_case(8'b0110_1110, 8'b1000_0001, 1'b0, 1'b0);
    // final update timeout (R8)
    run_case(8'b0011_1100, '0, 1'b1, 1'b0);
    run_case(8'b1111_1111, '0, 1'b1, 1'b0);
    // busy start pulses (R10)
    run_case(8'b0111_0110, '0, 1'b0, 1'b1);
    run_case(8'b0000_0000, '0, 1'b0, 1'b1);
    // err_o cleared by the next accepted start (R9)
    run_case(8'b0000_0000, '0, 1'b0, 1'b0);
    run_case(8'b0001_1000, '0, 1'b0, 1'b0);
    chk(!err_o, "R9 err cleared by new start", int'(err_o), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule